// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits between a processor's active-low memory chip-enable and the memory. While the system is healthy, the enable passes straight through to the memory. When a supply monitor or another reset source raises the reset-active flag, the gate stops any new access from reaching the memory. A write that is already in flight at that instant is not cut off in the middle.

If the enable is low when reset arrives, the gate keeps it low for a bounded grace period. The grace period ends after a parameterised number of clock cycles, or earlier if the processor releases the enable first. After that, the output is held at the inactive-high level until the reset flag drops. A fresh reset event always starts with a full grace window.

Top module: `ce_wp_gate`

## Requirements
- R1: After the synchronous reset `rst` is released, the gate is in pass-through and, with `rst_act` low, `ce_out_n` equals `ce_in_n`.
- R2: While `rst_act` has been low for at least one clock edge, `ce_out_n` equals `ce_in_n` in the same cycle, with no register delay.
- R3: If `ce_in_n` is high (1) in the first cycle in which `rst_act` is high, `ce_out_n` is 1 in every cycle while `rst_act` stays high, whatever `ce_in_n` does.
- R4: If `ce_in_n` is low (0) in the first cycle in which `rst_act` is high, `ce_out_n` stays 0 until `ce_in_n` goes to 1 or until GRACE_CYCLES consecutive low cycles have elapsed, whichever comes first. These cycles count from that first cycle. It is never low for more than GRACE_CYCLES cycles in one reset event.
- R5: Once `ce_out_n` has been 1 during a reset event, it stays 1 for the rest of that event.
- R6: A new falling edge on `ce_in_n` during a reset event never starts a new grace window.
- R7: In the first cycle after `rst_act` falls, `ce_out_n` is 1 if it was 1 in the cycle before. From the next cycle on, it follows `ce_in_n` again, going low if `ce_in_n` is low.
- R8: Every reset event gets a full GRACE_CYCLES window, however much of the window an earlier event used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the grace time is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset of the gate's own state |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| rst_act | input | 1 | High while the system reset condition is active |
| ce_out_n | output | 1 | Gated active-low chip-enable to the memory |

## Verification
Reset events are started with the enable both high and low at the moment of assertion. This separates the immediate-lock path from the grace path. Within the grace path, the enable is either held low past the window or released early. These cases tell the timer expiry apart from the early exit on release. Falling edges after lock-out, deassertion with the enable low, and back-to-back reset events check that the window neither restarts nor carries over. Long random runs mix short and long reset pulses with a busy enable against a cycle model in the bench.

// File: rtl/ce_gate_pkg.sv
package ce_gate_pkg;

    typedef enum logic [1:0] {
        GATE_PASS  = 2'd0,
        GATE_GRACE = 2'd1,
        GATE_LOCK  = 2'd2
    } gate_phase_e;

    typedef struct packed {
        logic        rst_act;
        logic        ce_n;
        logic        expired;
    } gate_view_t;

    function automatic gate_phase_e gate_next(gate_phase_e cur, gate_view_t v);
        gate_phase_e nxt;
        nxt = cur;
        unique case (cur)
            GATE_PASS:  if (v.rst_act) nxt = v.ce_n ? GATE_LOCK : GATE_GRACE;
            GATE_GRACE: begin
                if (!v.rst_act)                nxt = GATE_PASS;
                else if (v.ce_n || v.expired)  nxt = GATE_LOCK;
            end
            GATE_LOCK:  if (!v.rst_act) nxt = GATE_PASS;
            default:    nxt = GATE_PASS;
        endcase
        return nxt;
    endfunction

    function automatic logic gate_drive(gate_phase_e cur, gate_view_t v);
        logic o;
        unique case (cur)
            GATE_PASS:  o = v.ce_n;
            GATE_GRACE: o = v.ce_n | v.expired;
            default:    o = 1'b1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/ce_gate_timer.sv
module ce_gate_timer #(
    parameter int GRACE_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(GRACE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GRACE_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)             cnt <= '0;
        else if (load)                cnt <= CNT_W'(1);
        else if (run && !expired)     cnt <= cnt + CNT_W'(1);
    end

    assign expired = (cnt >= LIMIT);
endmodule

// File: rtl/ce_gate_seq.sv
module ce_gate_seq
    import ce_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  gate_view_t  view,
    output gate_phase_e phase,
    output logic        t_clear,
    output logic        t_load,
    output logic        t_run
);
    always_ff @(posedge clk) begin
        if (rst) phase <= GATE_PASS;
        else     phase <= gate_next(phase, view);
    end

    always_comb begin
        t_clear = !view.rst_act;
        t_load  = (phase == GATE_PASS)  && view.rst_act && !view.ce_n;
        t_run   = (phase == GATE_GRACE) && view.rst_act && !view.ce_n;
    end
endmodule

// File: rtl/ce_gate_drive.sv
module ce_gate_drive
    import ce_gate_pkg::*;
(
    input  gate_phase_e phase,
    input  gate_view_t  view,
    output logic        ce_out_n
);
    assign ce_out_n = gate_drive(phase, view);
endmodule

// File: rtl/ce_wp_gate.sv
module ce_wp_gate
    import ce_gate_pkg::*;
#(
    parameter int GRACE_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_in_n,
    input  logic rst_act,
    output logic ce_out_n
);
    gate_phase_e phase;
    gate_view_t  view;
    logic        t_clear, t_load, t_run, expired;

    assign view = '{rst_act: rst_act, ce_n: ce_in_n, expired: expired};

    ce_gate_seq u_seq (
        .clk(clk), .rst(rst), .view(view), .phase(phase),
        .t_clear(t_clear), .t_load(t_load), .t_run(t_run)
    );

    ce_gate_timer #(.GRACE_CYCLES(GRACE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .clear(t_clear), .load(t_load),
        .run(t_run), .expired(expired)
    );

    ce_gate_drive u_drive (
        .phase(phase), .view(view), .ce_out_n(ce_out_n)
    );
endmodule

// File: rtl/ce_wp_gate_chk.sv
module ce_wp_gate_chk #(
    parameter int GRACE_CYCLES = 12
) (
    input logic clk,
    input logic rst,
    input logic ce_in_n,
    input logic rst_act,
    input logic ce_out_n
);
    int low_run;

    always_ff @(posedge clk) begin
        if (rst || !rst_act)  low_run <= 0;
        else if (!ce_out_n)   low_run <= low_run + 1;
    end

    // R2
    pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_act && !$past(rst_act) && !$past(rst)) |-> (ce_out_n == ce_in_n));

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_act && $past(rst_act) && !$past(rst) && $past(ce_out_n)) |-> ce_out_n);

    // R4
    grace_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_act && !ce_out_n) |-> (low_run < GRACE_CYCLES));

    // R7
    release_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst_act) && !$past(rst) && $past(ce_out_n)) |-> ce_out_n);

    // R3
    high_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_act && !$past(rst_act) && !$past(rst) && ce_in_n) |-> ce_out_n);
endmodule

bind ce_wp_gate ce_wp_gate_chk #(.GRACE_CYCLES(GRACE_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .rst_act(rst_act), .ce_out_n(ce_out_n)
);

// File: tb/ce_wp_gate_test.sv
module ce_wp_gate_test;
    localparam int G = 12;

    logic clk = 1'b0;
    logic rst, ce_in_n, rst_act;
    logic ce_out_n;
    int   checks = 0, errors = 0;

    // bench model: 0 pass, 1 grace, 2 locked
    int   m_ph = 0, m_used = 0;

    ce_wp_gate #(.GRACE_CYCLES(G)) uut (
        .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .rst_act(rst_act), .ce_out_n(ce_out_n)
    );

    always #4 clk = ~clk;

    function automatic logic exp_out(logic ce);
        if (m_ph == 0) return ce;
        if (m_ph == 1) return ce | (m_used >= G);
        return 1'b1;
    endfunction

    function automatic string tag_of(logic ra);
        if (!ra && m_ph == 0) return "R2";
        if (!ra)              return "R7";
        if (m_ph == 1)        return "R4";
        if (m_ph == 2)        return "R5";
        return "R3";
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ce_out_n=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(logic ce, logic ra);
        case (m_ph)
            0: if (ra) begin
                   if (!ce) begin m_ph = 1; m_used = 1; end
                   else m_ph = 2;
               end
            1: if (!ra) begin m_ph = 0; m_used = 0; end
               else if (ce || m_used >= G) m_ph = 2;
               else m_used++;
            default: if (!ra) begin m_ph = 0; m_used = 0; end
        endcase
    endtask

    // one cycle: drive, compare, advance model
    task automatic cyc(logic ce, logic ra, string req = "");
        logic e;
        @(negedge clk);
        ce_in_n = ce; rst_act = ra;
        #2;
        e = exp_out(ce);
        check(req == "" ? tag_of(ra) : req, ce_out_n, e);
        @(posedge clk);
        model_step(ce, ra);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lows;
        void'($urandom(32'd1234));
        rst = 1'b1; ce_in_n = 1'b1; rst_act = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state, pass-through both levels
        cyc(1'b0, 1'b0, "R1");
        cyc(1'b1, 1'b0, "R1");
        cyc(1'b0, 1'b0, "R2");

        // R3 / R6: enter with enable high, then toggle
        cyc(1'b1, 1'b1, "R3");
        for (int i = 0; i < 6; i++) cyc(i[0], 1'b1, "R6");
        cyc(1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b0, "R7");

        // R4: enable held low past the window, count the low cycles
        cyc(1'b1, 1'b0);
        lows = 0;
        for (int i = 0; i < G + 5; i++) begin
            cyc(1'b0, 1'b1, "R4");
            if (ce_out_n === 1'b0) lows++;
        end
        check("R4", lows == G, 1'b1);
        cyc(1'b1, 1'b1, "R6");
        cyc(1'b0, 1'b1, "R6");
        cyc(1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b0, "R7");

        // R4 early release, then R6 re-fall stays locked
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1, "R4");
        cyc(1'b0, 1'b1, "R4");
        cyc(1'b1, 1'b1, "R4");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R6");
        cyc(1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b0, "R7");

        // R8: two reset events back to back, both get the full window
        for (int k = 0; k < 2; k++) begin
            cyc(1'b0, 1'b0);
            lows = 0;
            for (int i = 0; i < G + 2; i++) begin
                cyc(1'b0, 1'b1, "R8");
                if (ce_out_n === 1'b0) lows++;
            end
            check("R8", lows == G, 1'b1);
        end
        cyc(1'b1, 1'b0, "R7");

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic ra;
            ra = (m_ph == 0) ? ($urandom % 16 == 0) : ($urandom % 24 != 0);
            cyc(logic'($urandom % 3 == 0), ra);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule